// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events for a small processor core and turns them into vector requests. Four external pins pass through a synchronizer and an edge detector, and a parameterized vector of peripheral event pulses feeds the same flag bank. Each source has a pending flag, an enable bit and a priority bit. One control register holds two top-level enables, a priority-mode bit and one edge-select bit per external pin. The block drives a high-level request and a low-level request toward the core.

With priority mode on, the two top enables act as separate high and low gates. Taking a vector clears only the gate of the level that was taken, so a high source can still interrupt a low handler. With priority mode off, the upper enable is a single global gate and the lower one gates only peripheral sources. In that mode every vector is reported on the high request line. The core pulses a take input when it vectors and a return input when a handler ends. On return the controller sets back the enable it cleared.

Flags record events whatever the enables hold, so software can poll them. Software clears a flag by writing 0 to it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0F: both top enables and priority mode are 0, and the four edge selects are 1. All flags are 0 and both requests are low.
- R2: A flag is set by its event while the top enables and its own enable are 0, and no request follows from it.
- R3: External pin n sets flag bit n on a rising edge when control bit n is 1 and on a falling edge when it is 0. An edge of the other kind has no effect. The flag becomes visible on the third rising clock edge after the pin changes. Peripheral event i sets flag bit 4+i.
- R4: With priority mode on (control bit 5), irq_hi_o is high when control bit 7 is 1 and some enabled flag has its priority bit at 1. A take while irq_hi_o is high clears bit 7 and leaves bit 6 unchanged.
- R5: With priority mode on, irq_lo_o is high when bits 7 and 6 are 1, some enabled flag has priority 0 and irq_hi_o is low. A take while only irq_lo_o is high clears bit 6 and keeps bit 7, so a high source pending afterwards raises irq_hi_o.
- R6: While bit 7 is 0, irq_lo_o stays low even with bit 6 set and a low source pending.
- R7: With priority mode off, irq_lo_o is always low. irq_hi_o is high when bit 7 is 1 and either an enabled external flag is pending, or bit 6 is 1 and an enabled peripheral flag is pending. Priority bits are ignored, and a take clears bit 7.
- R8: A return pulse sets bit 6 when priority mode is on and ret_hi_i is 0. In every other case it sets bit 7.
- R9: A flag write with bit value 0 clears that flag and a bit value 1 keeps it. If a new event for a flag arrives in the same cycle as the clearing write, the flag ends up set. No flag is cleared without a write.
- R10: reg_sel_i selects the written register: 0 control, 1 flags, 2 enables, 3 priorities. A source raises no request while its enable bit is 0. A take or return in the same cycle as a control write overrides the written value of the bit it acts on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 4 | External interrupt pins, asynchronous |
| periph_evt_i | input | NP | Peripheral event pulses, one cycle each |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | DW | Write data |
| vec_take_i | input | 1 | Core is taking the active vector |
| ret_i | input | 1 | Return-from-interrupt pulse |
| ret_hi_i | input | 1 | Return is from the high level |
| ctrl_o | output | 8 | Control register contents |
| flag_o | output | NS | Pending flags: external in 3:0, peripheral above |
| irq_hi_o | output | 1 | High-level (or single-level) vector request |
| irq_lo_o | output | 1 | Low-level vector request |

## Verification
The bench steps through nested entries. A low handler is preempted by a high source, and while that high handler runs a pending low source must stay silent. A design that cleared the wrong enable on a take, or gated low requests only on the low enable, would nest the wrong way. The bench also sets a flag in the same cycle as a clearing write; an implementation with the wrong priority loses the event. It changes a pin against its edge select, which a design ignoring the select would flag. Finally it uses compatibility mode with the peripheral gate off, where an external source must still interrupt and priority bits must not split requests onto the low line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_EXT = 4;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned CB_HI_EN = 7;
  localparam int unsigned CB_LO_EN = 6;
  localparam int unsigned CB_PRIO  = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h0F;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EN   = 2'd2,
    SEL_PRIO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_sel_i,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] sh_q; // [0],[1] synchronizer, [2] previous synced value

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], pin_i[g]};
    end

    assign evt_o[g] = edge_sel_i[g] ? (sh_q[1] & ~sh_q[2]) : (~sh_q[1] & sh_q[2]);

    AST_EDGE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[g] |=> !evt_o[g]); // R3
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] evt_i,
  input  logic          clr_we_i,
  input  logic [NS-1:0] keep_i,
  output logic [NS-1:0] flag_o
);
  logic [NS-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_we_i) flag_d = flag_q & keep_i;
    flag_d = flag_d | evt_i; // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (($past(flag_q) & ~flag_q) == '0)); // R9
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              take_i,
  input  logic              req_hi_i,
  input  logic              req_lo_i,
  input  logic              ret_i,
  input  logic              ret_hi_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] q, d;

  // order: software write, then take clear, then return set
  always_comb begin
    d = q;
    if (we_i) d = wdata_i;
    if (take_i) begin
      if (req_hi_i)      d[CB_HI_EN] = 1'b0;
      else if (req_lo_i) d[CB_LO_EN] = 1'b0;
    end
    if (ret_i) begin
      if (q[CB_PRIO] && !ret_hi_i) d[CB_LO_EN] = 1'b1;
      else                         d[CB_HI_EN] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RST;
    else         q <= d;
  end

  assign ctrl_o = q;

  AST_HI_TAKE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && req_hi_i && !ret_i) |=> !q[CB_HI_EN]); // R4
  AST_LO_TAKE_KEEP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !req_hi_i && req_lo_i && !ret_i && !we_i)
      |=> (!q[CB_LO_EN] && q[CB_HI_EN] == $past(q[CB_HI_EN]))); // R5
  AST_RET_SETS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && (!q[CB_PRIO] || ret_hi_i)) |=> q[CB_HI_EN]); // R8
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
#(
  parameter int unsigned NS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [NS-1:0]     flag_i,
  input  logic [NS-1:0]     en_i,
  input  logic [NS-1:0]     prio_i,
  output logic              irq_hi_o,
  output logic              irq_lo_o
);
  logic [NS-1:0] pend;
  logic ext_pend, per_pend, hi_pend, lo_pend;
  logic hi_en, lo_en, prio_mode;

  assign hi_en     = ctrl_i[CB_HI_EN];
  assign lo_en     = ctrl_i[CB_LO_EN];
  assign prio_mode = ctrl_i[CB_PRIO];

  assign pend     = flag_i & en_i;
  assign ext_pend = |pend[NUM_EXT-1:0];
  assign per_pend = |pend[NS-1:NUM_EXT];
  assign hi_pend  = |(pend & prio_i);
  assign lo_pend  = |(pend & ~prio_i);

  always_comb begin
    if (prio_mode) begin
      irq_hi_o = hi_en & hi_pend;
      irq_lo_o = hi_en & lo_en & lo_pend & ~irq_hi_o;
    end else begin
      irq_hi_o = hi_en & (ext_pend | (lo_en & per_pend));
      irq_lo_o = 1'b0;
    end
  end

  AST_LO_NEEDS_HI_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> (ctrl_i[CB_HI_EN] && ctrl_i[CB_LO_EN] && ctrl_i[CB_PRIO])); // R6
  AST_ONE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_hi_o && irq_lo_o)); // R5
  AST_HI_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> ctrl_i[CB_HI_EN]); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NP = 8,
  localparam int unsigned NS = NUM_EXT + NP,
  localparam int unsigned DW = (NS > CTRL_W) ? NS : CTRL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [NP-1:0]      periph_evt_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [DW-1:0]      reg_wdata_i,
  input  logic               vec_take_i,
  input  logic               ret_i,
  input  logic               ret_hi_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [NS-1:0]      flag_o,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic [NUM_EXT-1:0] ext_evt;
  logic [NS-1:0]      evt_all;
  logic [NS-1:0]      en_q, prio_q;
  logic               we_ctrl, we_flag, we_en, we_prio;

  assign we_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign we_flag = reg_we_i && (reg_sel_i == SEL_FLAG);
  assign we_en   = reg_we_i && (reg_sel_i == SEL_EN);
  assign we_prio = reg_we_i && (reg_sel_i == SEL_PRIO);

  irq_ext_sync #(.N(NUM_EXT)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .edge_sel_i (ctrl_o[NUM_EXT-1:0]),
    .evt_o      (ext_evt)
  );

  assign evt_all = {periph_evt_i, ext_evt};

  irq_flag_bank #(.NS(NS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_all),
    .clr_we_i (we_flag),
    .keep_i   (reg_wdata_i[NS-1:0]),
    .flag_o   (flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (we_en)   en_q   <= reg_wdata_i[NS-1:0];
      if (we_prio) prio_q <= reg_wdata_i[NS-1:0];
    end
  end

  irq_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_ctrl),
    .wdata_i  (reg_wdata_i[CTRL_W-1:0]),
    .take_i   (vec_take_i),
    .req_hi_i (irq_hi_o),
    .req_lo_i (irq_lo_o),
    .ret_i    (ret_i),
    .ret_hi_i (ret_hi_i),
    .ctrl_o   (ctrl_o)
  );

  irq_resolve #(.NS(NS)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_o),
    .flag_i   (flag_o),
    .en_i     (en_q),
    .prio_i   (prio_q),
    .irq_hi_o (irq_hi_o),
    .irq_lo_o (irq_lo_o)
  );

  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hi_o || irq_lo_o) |-> ((flag_o & en_q) != '0)); // R10
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NP = 8;
  localparam int NS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]    pin = '0;
  logic [NP-1:0] pevt = '0;
  logic          we = 1'b0;
  logic [1:0]    sel = '0;
  logic [NS-1:0] wd = '0;
  logic          take = 1'b0, ret = 1'b0, ret_hi = 1'b0;
  logic [7:0]    ctrl;
  logic [NS-1:0] flag;
  logic          hi, lo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  prio_irq_ctrl #(.NP(NP)) u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(pin), .periph_evt_i(pevt),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
    .vec_take_i(take), .ret_i(ret), .ret_hi_i(ret_hi),
    .ctrl_o(ctrl), .flag_o(flag), .irq_hi_o(hi), .irq_lo_o(lo)
  );

  typedef struct packed {
    logic [2:0]  top;  // ctrl bits 7..5
    logic [7:0]  pf;   // peripheral events to raise
    logic [11:0] en;
    logic [11:0] prio;
    logic        hi;
    logic        lo;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'b111, 8'h01, 12'h010, 12'h010, 1'b1, 1'b0},
    '{3'b111, 8'h01, 12'h010, 12'h000, 1'b0, 1'b1},
    '{3'b111, 8'h01, 12'h000, 12'h000, 1'b0, 1'b0},
    '{3'b011, 8'h01, 12'h010, 12'h000, 1'b0, 1'b0},
    '{3'b101, 8'h01, 12'h010, 12'h000, 1'b0, 1'b0},
    '{3'b111, 8'h03, 12'h030, 12'h020, 1'b1, 1'b0},
    '{3'b100, 8'h01, 12'h010, 12'h000, 1'b0, 1'b0},
    '{3'b110, 8'h01, 12'h010, 12'h000, 1'b1, 1'b0},
    '{3'b010, 8'h01, 12'h010, 12'h000, 1'b0, 1'b0},
    '{3'b110, 8'h01, 12'h010, 12'h010, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [NS-1:0] d);
    @(negedge clk); we = 1'b1; sel = s; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_evt(input logic [NP-1:0] p);
    @(negedge clk); pevt = p;
    @(negedge clk); pevt = '0;
  endtask

  task automatic do_take();
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
  endtask

  task automatic do_ret(input logic h);
    @(negedge clk); ret = 1'b1; ret_hi = h;
    @(negedge clk); ret = 1'b0; ret_hi = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl reset", ctrl, 8'h0F);
    chk("R1 flags reset", flag, 0);
    chk("R1 hi reset", hi, 0);
    chk("R1 lo reset", lo, 0);

    // table walk
    for (int r = 0; r < NV; r++) begin
      wr(2'd0, 12'h00F);
      wr(2'd1, 12'h000);
      pulse_evt(VEC[r].pf);
      wr(2'd2, VEC[r].en);
      wr(2'd3, VEC[r].prio);
      wr(2'd0, {4'h0, VEC[r].top, 5'h0F});
      chk($sformatf("%s table row %0d hi", VEC[r].top[0] ? "R5" : "R7", r), hi, VEC[r].hi);
      chk($sformatf("%s table row %0d lo", VEC[r].top[0] ? "R5" : "R7", r), lo, VEC[r].lo);
    end

    // R3 edge selection and latency
    wr(2'd0, 12'h00F);
    wr(2'd1, 12'h000);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R3 flag not yet set", flag[0], 0);
    @(negedge clk); chk("R3 rising sets flag", flag[0], 1);
    chk("R2 no request when disabled", hi, 0);
    wr(2'd1, 12'h000);
    @(negedge clk); pin[0] = 1'b0;
    wait_n(4); chk("R3 falling ignored when rising selected", flag[0], 0);
    wr(2'd0, 12'h00E);
    @(negedge clk); pin[0] = 1'b1;
    wait_n(4); chk("R3 rising ignored when falling selected", flag[0], 0);
    @(negedge clk); pin[0] = 1'b0;
    wait_n(3); chk("R3 falling sets flag", flag[0], 1);
    pulse_evt(8'h04);
    chk("R3 peripheral 2 maps to flag 6", flag, 12'h041);
    wr(2'd0, 12'h00F);

    // R9 flag clearing rules
    wr(2'd1, 12'h000);
    @(negedge clk); pevt = 8'h01; we = 1'b1; sel = 2'd1; wd = 12'h000;
    @(negedge clk); pevt = '0; we = 1'b0;
    chk("R9 set wins over clear", flag, 12'h010);
    wr(2'd1, 12'hFFF);
    chk("R9 write 1 keeps flag", flag, 12'h010);
    wr(2'd1, 12'hFEF);
    chk("R9 write 0 clears flag", flag, 12'h000);

    // priority mode nesting
    wr(2'd2, 12'h030);
    wr(2'd3, 12'h020);
    wr(2'd0, 12'h02F);
    pulse_evt(8'h01);
    chk("R2 flag polled while masked", flag, 12'h010);
    chk("R2 no low request while masked", lo, 0);
    wr(2'd0, 12'h0EF);
    chk("R5 low request", lo, 1);
    do_take();
    chk("R5 take clears low enable only", ctrl, 8'hAF);
    chk("R5 low request drops", lo, 0);
    pulse_evt(8'h02);
    chk("R5 high preempts low handler", hi, 1);
    do_take();
    chk("R4 take clears high enable", ctrl, 8'h2F);
    chk("R4 high request drops", hi, 0);
    wr(2'd1, 12'hFDF);
    do_ret(1'b1);
    chk("R8 high return sets bit 7", ctrl, 8'hAF);
    chk("R8 low still masked", lo, 0);
    do_ret(1'b0);
    chk("R8 low return sets bit 6", ctrl, 8'hEF);
    chk("R8 low request resumes", lo, 1);
    pulse_evt(8'h02);
    chk("R4 high over low", hi, 1);
    chk("R4 low suppressed by high", lo, 0);
    do_take();
    chk("R6 ctrl during high service", ctrl, 8'h6F);
    chk("R6 low cannot preempt high", lo, 0);
    do_ret(1'b1);
    chk("R8 high return re-arms", hi, 1);

    // compatibility mode
    wr(2'd1, 12'h000);
    wr(2'd2, 12'h011);
    wr(2'd0, 12'h08F);
    @(negedge clk); pin[0] = 1'b1;
    wait_n(3);
    chk("R7 external ungated by bit 6", hi, 1);
    chk("R7 no low request", lo, 0);
    do_take();
    chk("R7 take clears bit 7", ctrl, 8'h0F);
    chk("R7 request drops", hi, 0);
    do_ret(1'b0);
    chk("R8 return sets bit 7 in single mode", ctrl, 8'h8F);
    @(negedge clk); take = 1'b1; we = 1'b1; sel = 2'd0; wd = 12'h0CF;
    @(negedge clk); take = 1'b0; we = 1'b0;
    chk("R10 take overrides control write", ctrl, 8'h4F);
    wr(2'd2, 12'h000);
    wr(2'd0, 12'h0CF);
    chk("R10 disabled source gives no request", hi, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule